// File: doc/BRIEF.md
# PWM Duty-Cycle to Code Converter

This block turns a pulse-width modulated logic signal into a binary code that is proportional to its duty ratio. The input is asynchronous to the system clock. It is synchronized first. The block then counts the high time and the full period of every PWM cycle in system clock cycles. On each rising edge that closes a measured period, it divides the two counts and presents an 8, 10 or 12 bit code. Because the code is a ratio, the PWM frequency does not affect it.

When the input stops toggling for longer than the longest legal period, the block sees a constant level and applies an idle policy. In sample/hold mode, a steady high keeps the last code with the output enabled, and a steady low drops the output-enable flag. In transparent mode, a steady high forces full scale and a steady low forces zero. The outputs are meant to feed a downstream converter: the code, a one-cycle update strobe, and an enable flag for that converter's high-impedance control.

Top module: `pwm2code`

## Requirements
- R1: After reset, `code_o` is 0 and `upd_o` is 0. `oe_o` is 0 when `hold_mode_i` is 1 and 1 when `hold_mode_i` is 0.
- R2: The resolution select works as follows: 00 gives N=8, 01 gives N=10, and 10 or 11 give N=12. With high time H and period P counted in clock cycles of the synchronized input, the code equals floor(H·2^N/P). It is right-aligned in `code_o[11:0]` and the unused upper bits are 0.
- R3: Each rising edge that closes a measured period produces exactly one single-cycle `upd_o` pulse, within 20 clocks of the input edge. `code_o` changes only alongside `upd_o`. Periods must be at least 16 clocks long.
- R4: The first rising edge after reset or after an idle interval only starts a measurement and produces no update.
- R5: When no edge is seen for IDLE_CYC clocks, the input is treated as idle. A period that runs this long is discarded.
- R6: In sample/hold mode, `oe_o` stays 0 from reset until the first completed measurement.
- R7: In sample/hold mode, an idle-high input keeps `code_o` unchanged and `oe_o` at 1, with no `upd_o` pulse.
- R8: In sample/hold mode, an idle-low input clears `oe_o`. The next completed measurement sets it again. `upd_o` never pulses while `oe_o` is 0.
- R9: In transparent mode, an idle-high input loads full scale 2^N−1 with one `upd_o` pulse.
- R10: In transparent mode, an idle-low input loads 0 with one `upd_o` pulse.
- R11: `code_o` never exceeds 2^N−1 for the selected resolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | Asynchronous PWM input |
| hold_mode_i | input | 1 | Idle policy: 1 sample/hold, 0 transparent |
| res_sel_i | input | 2 | Resolution select (00: 8, 01: 10, 1x: 12 bits) |
| code_o | output | 12 | Duty-cycle code, right-aligned |
| upd_o | output | 1 | One-cycle strobe when a new code is valid |
| oe_o | output | 1 | Output enable for the downstream converter |

## Verification
The main function is driven with bursts of PWM cycles. These cover a single-cycle high time, a high time one cycle short of the period, round binary ratios and non-integer ratios, all at every resolution setting including the redundant 11 select. Round ratios pin down the scaling by 2^N. Near-full and odd ratios expose truncation and off-by-one errors in the high and period counters. Counting strobes per burst separates a missing update from a spurious one on the arming edge. Idle-high and idle-low intervals in both modes, plus a period stretched past the idle limit, tell the hold, tri-state and forcing policies apart and show that the next edge does not re-enable the output.

// File: rtl/pwm2code_pkg.sv
package pwm2code_pkg;
  localparam int unsigned CODE_W = 12;
  localparam int unsigned NB_W   = 4;

  typedef enum logic [1:0] {
    RES_8   = 2'b00,
    RES_10  = 2'b01,
    RES_12  = 2'b10,
    RES_12X = 2'b11
  } res_e;

  function automatic logic [NB_W-1:0] res_bits(input logic [1:0] sel);
    case (res_e'(sel))
      RES_8:   return NB_W'(8);
      RES_10:  return NB_W'(10);
      default: return NB_W'(12);
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] full_scale(input logic [1:0] sel);
    return CODE_W'((1 << res_bits(sel)) - 1);
  endfunction
endpackage

// File: rtl/pwm2code_sync.sv
module pwm2code_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] ff_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      ff_q   <= {ff_q[STAGES-2:0], async_i};
      prev_q <= ff_q[STAGES-1];
    end
  end

  assign lvl_o  = ff_q[STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;

  // R3: the level is held through a rise, so two rises cannot come back to back
  p_rise_spaced_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pwm2code_meter.sv
module pwm2code_meter #(
  parameter int unsigned IDLE_CYC = 4_250_000,
  parameter int unsigned CNT_W    = $clog2(IDLE_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic             meas_v_o,
  output logic [CNT_W-1:0] hi_o,
  output logic [CNT_W-1:0] per_o,
  output logic             idle_v_o,
  output logic             idle_lvl_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] QUIET_LM = CNT_W'(IDLE_CYC - 1);

  logic [CNT_W-1:0] per_q, hi_q, quiet_q;
  logic             armed_q, idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q      <= '0;
      hi_q       <= '0;
      quiet_q    <= '0;
      armed_q    <= 1'b0;
      idle_q     <= 1'b0;
      meas_v_o   <= 1'b0;
      hi_o       <= '0;
      per_o      <= '0;
      idle_v_o   <= 1'b0;
      idle_lvl_o <= 1'b0;
    end else begin
      meas_v_o <= 1'b0;
      idle_v_o <= 1'b0;
      if (rise_i) begin
        if (armed_q) begin
          meas_v_o <= 1'b1;
          hi_o     <= hi_q;
          per_o    <= per_q;
        end
        armed_q <= 1'b1;
        per_q   <= CNT_W'(1);
        hi_q    <= CNT_W'(1);
        quiet_q <= '0;
        idle_q  <= 1'b0;
      end else begin
        if (per_q != CNT_MAX)         per_q <= per_q + 1'b1;
        if (lvl_i && hi_q != CNT_MAX) hi_q  <= hi_q + 1'b1;
        if (fall_i) begin
          quiet_q <= '0;
          idle_q  <= 1'b0;
        end else if (!idle_q) begin
          if (quiet_q == QUIET_LM) begin
            idle_q     <= 1'b1;
            idle_v_o   <= 1'b1;
            idle_lvl_o <= lvl_i;
            armed_q    <= 1'b0;   // R5: an overlong period is dropped
          end else begin
            quiet_q <= quiet_q + 1'b1;
          end
        end
      end
    end
  end

  // R2: a closed period always contains at least one low cycle
  p_meas_ratio_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_v_o |-> (hi_o < per_o));
  // R5: idle entry and a measurement are never reported together
  p_idle_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_v_o |-> !meas_v_o);
endmodule

// File: rtl/pwm2code_div.sv
module pwm2code_div
  import pwm2code_pkg::*;
#(
  parameter int unsigned CNT_W = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        res_i,
  input  logic [CNT_W-1:0]  num_i,
  input  logic [CNT_W-1:0]  den_i,
  output logic              done_o,
  output logic [CODE_W-1:0] q_o
);
  logic [CNT_W:0]      rem_q, den_q, rem_sh;
  logic [CODE_W-1:0]   quo_q, fs;
  logic [NB_W-1:0]     cnt_q;
  logic [1:0]          res_q;
  logic                busy_q;

  assign rem_sh = {rem_q[CNT_W-1:0], 1'b0};
  assign fs     = full_scale(res_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      res_q  <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rem_q  <= {1'b0, num_i};
        den_q  <= {1'b0, den_i};
        quo_q  <= '0;
        cnt_q  <= res_bits(res_i);
        res_q  <= res_i;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (rem_sh >= den_q) begin
          rem_q <= rem_sh - den_q;
          quo_q <= {quo_q[CODE_W-2:0], 1'b1};
        end else begin
          rem_q <= rem_sh;
          quo_q <= {quo_q[CODE_W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == NB_W'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  assign q_o = (quo_q > fs) ? fs : quo_q;

  // R11: a finished quotient fits the selected resolution
  p_quot_range_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (quo_q <= fs));
endmodule

// File: rtl/pwm2code.sv
module pwm2code
  import pwm2code_pkg::*;
#(
  parameter int unsigned IDLE_CYC    = 4_250_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwm_i,
  input  logic              hold_mode_i,
  input  logic [1:0]        res_sel_i,
  output logic [CODE_W-1:0] code_o,
  output logic              upd_o,
  output logic              oe_o
);
  localparam int unsigned CNT_W = $clog2(IDLE_CYC + 1);

  logic              lvl, rise, fall;
  logic              meas_v, idle_v, idle_lvl, div_done;
  logic [CNT_W-1:0]  hi_cnt, per_cnt;
  logic [CODE_W-1:0] div_q, code_q;
  logic              upd_q, oe_q;

  pwm2code_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .async_i(pwm_i),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  pwm2code_meter #(.IDLE_CYC(IDLE_CYC), .CNT_W(CNT_W)) u_meter (
    .clk_i, .rst_ni, .lvl_i(lvl), .rise_i(rise), .fall_i(fall),
    .meas_v_o(meas_v), .hi_o(hi_cnt), .per_o(per_cnt),
    .idle_v_o(idle_v), .idle_lvl_o(idle_lvl)
  );

  pwm2code_div #(.CNT_W(CNT_W)) u_div (
    .clk_i, .rst_ni, .start_i(meas_v), .res_i(res_sel_i),
    .num_i(hi_cnt), .den_i(per_cnt), .done_o(div_done), .q_o(div_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      upd_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (div_done) begin
        code_q <= div_q;
        upd_q  <= 1'b1;
        oe_q   <= 1'b1;
      end else if (idle_v) begin
        if (hold_mode_i) begin
          if (!idle_lvl) oe_q <= 1'b0;
        end else begin
          code_q <= idle_lvl ? full_scale(res_sel_i) : '0;
          upd_q  <= 1'b1;
          oe_q   <= 1'b1;
        end
      end
    end
  end

  assign code_o = code_q;
  assign upd_o  = upd_q;
  assign oe_o   = hold_mode_i ? oe_q : 1'b1;

  p_upd_enables_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> oe_o);
  p_idle_low_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_mode_i && idle_v && !idle_lvl && !div_done) |=> !oe_q);
  p_hold_high_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_mode_i && idle_v && idle_lvl && !div_done) |=> ($stable(code_o) && !upd_o));
  p_trans_fs_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_mode_i && idle_v && idle_lvl && !div_done)
      |=> (code_o == full_scale($past(res_sel_i))));
  p_trans_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_mode_i && idle_v && !idle_lvl && !div_done) |=> (code_o == '0));
  p_code_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o |-> $stable(code_o));
endmodule

// File: tb/pwm2code_test.sv
module pwm2code_test;
  localparam int IDLE = 400;
  localparam int NV   = 9;
  // {res_sel, high, period}
  localparam int VEC [0:NV-1][0:2] = '{
    '{0, 50, 200}, '{1, 1, 100},  '{2, 99, 100},
    '{0, 150, 256}, '{2, 77, 300}, '{1, 200, 201},
    '{2, 40, 64},  '{3, 33, 97},  '{0, 1, 16}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwm = 1'b0;
  logic        hold = 1'b1;
  logic [1:0]  res = 2'b00;
  logic [11:0] code;
  logic        upd, oe;

  int n_chk = 0, n_bad = 0, n_upd = 0;
  logic [11:0] last_code = '0;
  bit finished = 0;

  always #4 clk = ~clk;

  pwm2code #(.IDLE_CYC(IDLE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pwm_i(pwm), .hold_mode_i(hold),
    .res_sel_i(res), .code_o(code), .upd_o(upd), .oe_o(oe)
  );

  always @(negedge clk) if (rst_n && upd) begin
    n_upd++;
    last_code = code;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pwm_run(input int h, input int p, input int k);
    for (int i = 0; i < k; i++) begin
      pwm = 1'b1; cyc(h);
      pwm = 1'b0; cyc(p - h);
    end
  endtask

  function automatic int nbits(input int sel);
    return (sel == 0) ? 8 : (sel == 1) ? 10 : 12;
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    cyc(3);
    chk("R1 code", int'(code), 0);
    chk("R1 upd", int'(upd), 0);
    chk("R1 oe hold", int'(oe), 0);
    rst_n = 1'b1;
    cyc(2);
    hold = 1'b0; cyc(1);
    chk("R1 oe transparent", int'(oe), 1);
    hold = 1'b1; cyc(1);

    // R6: a lone rise does not enable the output
    n_upd = 0;
    pwm = 1'b1; cyc(30); pwm = 1'b0; cyc(30);
    chk("R6 no update", n_upd, 0);
    chk("R6 oe low", int'(oe), 0);

    for (int v = 0; v < NV; v++) begin
      int n, exp;
      pwm = 1'b0; cyc(IDLE + 20);
      res = 2'(VEC[v][0]);
      n = nbits(VEC[v][0]);
      exp = (VEC[v][1] << n) / VEC[v][2];
      n_upd = 0;
      pwm_run(VEC[v][1], VEC[v][2], 3);
      pwm = 1'b1; cyc(40);
      chk("R3/R4 update count", n_upd, 3);
      chk("R2 code", int'(last_code), exp);
      chk("R2 port code", int'(code), exp);
      chk("R11 in range", int'(code <= 12'((1 << n) - 1)), 1);
      chk("R8 oe after update", int'(oe), 1);
      pwm = 1'b0;
    end

    // R7: idle high in hold mode
    cyc(IDLE + 20);
    res = 2'b01;
    pwm_run(60, 120, 2);
    pwm = 1'b1; cyc(40);
    chk("R7 code before idle", int'(code), 512);
    n_upd = 0;
    cyc(IDLE + 40);
    chk("R7 no update", n_upd, 0);
    chk("R7 code held", int'(code), 512);
    chk("R7 oe kept", int'(oe), 1);

    // R8: idle low drops oe, next measurement restores it
    pwm = 1'b0; cyc(IDLE + 40);
    chk("R8 oe dropped", int'(oe), 0);
    chk("R8 no update", n_upd, 0);
    pwm_run(30, 100, 1);
    pwm = 1'b1; cyc(40);
    chk("R8 one update", n_upd, 1);
    chk("R8 oe restored", int'(oe), 1);
    chk("R8 code", int'(code), 307);

    // R5: overlong period is discarded
    pwm = 1'b0; cyc(IDLE + 20);
    n_upd = 0;
    pwm_run(50, 100, 2);
    pwm = 1'b1; cyc(50);
    pwm = 1'b0; cyc(IDLE + 50);
    pwm = 1'b1; cyc(40);
    chk("R5 update count", n_upd, 2);
    chk("R5 oe stays low", int'(oe), 0);

    // R9/R10: transparent mode forcing
    hold = 1'b0; res = 2'b01;
    n_upd = 0;
    cyc(IDLE + 40);
    chk("R9 full scale", int'(code), 1023);
    chk("R9 one update", n_upd, 1);
    pwm = 1'b0; cyc(IDLE + 40);
    chk("R10 zero", int'(code), 0);
    chk("R10 updates", n_upd, 2);
    chk("R10 oe", int'(oe), 1);
    res = 2'b10;
    pwm = 1'b1; cyc(IDLE + 40);
    chk("R9 full scale 12", int'(code), 4095);

    finished = 1;
    finish_run();
  end
endmodule